// File: doc/BRIEF.md
# Rank-Ordered Per-Flow Scheduling Queue

This block is a shared scheduling queue for a packet switch. Each arriving entry brings a flow number, a rank computed upstream and an opaque descriptor. Logically the entry takes its place in a single queue ordered by rank. Every removal takes the entry with the lowest rank. Entries with equal ranks leave in the order they arrived. Once an entry is buffered, later arrivals never change its position relative to the others.

Upstream logic must give each flow ranks that never decrease. Because of that rule, only the oldest entry of each flow can ever be the next to leave. The block therefore keeps one FIFO per flow, and only the flow heads, at most one per flow, take part in the ordering. An arrival-order tag attached to every accepted entry settles ties between flows.

A dequeue request is answered one cycle later with a valid flag, the flow, the rank and the descriptor. One enqueue and one dequeue can be accepted in every cycle. A per-flow full flag tells the source when a flow can take no more entries.

Top module: `rank_sched_queue`

## Requirements
- R1: A dequeue request that finds the queue non-empty raises deqValid in the next cycle and returns the buffered entry with the smallest rank.
- R2: When entries of different flows hold equal ranks, the one enqueued earlier leaves first.
- R3: Entries of one flow leave in the order they were enqueued, including entries of equal rank.
- R4: A dequeue request that finds the queue empty leaves deqValid low in the next cycle and changes nothing.
- R5: flowFull[f] is high exactly when flow f holds DEPTH entries. An enqueue to a full flow is dropped, and that flow's later output does not include it.
- R6: An enqueue and a dequeue accepted in the same cycle both take effect. The dequeue chooses among the entries buffered before that cycle, so a same-cycle arrival cannot be the one returned.
- R7: After reset the queue is empty, deqValid is low and every flowFull bit is low.
- R8: deqValid is high only in the cycle that follows a dequeue request.
- R9: A valid response carries the flow number and the rank that were enqueued with the returned descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Enqueue strobe |
| enqFlow | input | FLOW_W | Flow of the arriving entry |
| enqRank | input | RANK_W | Precomputed rank; must not decrease within a flow |
| enqDesc | input | DESC_W | Opaque descriptor stored with the entry |
| flowFull | output | NUM_FLOWS | Bit f high when flow f holds DEPTH entries |
| deqReq | input | 1 | Request to remove the lowest-rank entry |
| deqValid | output | 1 | Response valid, one cycle after the request |
| deqFlow | output | FLOW_W | Flow of the returned entry |
| deqRank | output | RANK_W | Rank of the returned entry |
| deqDesc | output | DESC_W | Descriptor of the returned entry |

## Verification
The assertions check on every cycle that a flow's occupancy stays within DEPTH, that an enqueue to a full flow with no pop leaves all occupancies unchanged, that every pop comes from a non-empty flow holding a rank no larger than any other head, and that a response only follows a request, never one made against an empty queue. Order across flows on rank ties, FIFO order inside a flow, the dropping of a rejected descriptor and the same-cycle enqueue-and-dequeue case can only be shown by the directed scenarios. Those scenarios compare the returned flow, rank and descriptor with a model of the queue.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // Flow fields in the strobe bundle are fixed-width so the type is shared;
  // modules compare them against zero-extended loop indices, never index by them.
  localparam int FLOW_ID_W = 8;

  typedef struct packed {
    logic                 push;
    logic [FLOW_ID_W-1:0] pushFlow;
    logic                 pop;
    logic [FLOW_ID_W-1:0] popFlow;
  } rsq_strobe_t;
endpackage

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
  import rsq_pkg::*;
#(
  parameter int NUM_FLOWS = 16,
  parameter int DEPTH     = 8,
  localparam int FLOW_W   = $clog2(NUM_FLOWS),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enqValid,
  input  logic [FLOW_W-1:0]    enqFlow,
  input  logic                 deqReq,
  input  logic                 anyHead,
  input  logic [FLOW_W-1:0]    winFlow,
  output rsq_strobe_t          strb,
  output logic [NUM_FLOWS-1:0] nonEmpty,
  output logic [NUM_FLOWS-1:0] flowFull
);

  logic [NUM_FLOWS-1:0][CNT_W-1:0] cnt, cntNext;

  always_comb begin
    for (int f = 0; f < NUM_FLOWS; f++) begin
      flowFull[f] = (cnt[f] == CNT_W'(DEPTH));
      nonEmpty[f] = (cnt[f] != '0);
    end
  end

  always_comb begin
    strb.push     = enqValid && !flowFull[enqFlow];
    strb.pushFlow = FLOW_ID_W'(enqFlow);
    strb.pop      = deqReq && anyHead;
    strb.popFlow  = FLOW_ID_W'(winFlow);
  end

  always_comb begin
    for (int f = 0; f < NUM_FLOWS; f++) begin
      cntNext[f] = cnt[f];
      if (strb.push && strb.pushFlow == FLOW_ID_W'(f)) cntNext[f] = cntNext[f] + CNT_W'(1);
      if (strb.pop && strb.popFlow == FLOW_ID_W'(f))   cntNext[f] = cntNext[f] - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cntNext;
  end

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : gen_cnt_chk
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CNT_W'(DEPTH));
  end

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enqValid && flowFull[enqFlow] && !deqReq) |=> $stable(cnt));

  assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> nonEmpty[winFlow]);

endmodule

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int NUM_FLOWS = 16,
  parameter int DEPTH     = 8,
  parameter int RANK_W    = 16,
  parameter int DESC_W    = 16,
  parameter int TAG_W     = 16,
  localparam int FLOW_W   = $clog2(NUM_FLOWS),
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rsq_strobe_t          strb,
  input  logic [NUM_FLOWS-1:0] nonEmpty,
  input  logic [RANK_W-1:0]    enqRank,
  input  logic [DESC_W-1:0]    enqDesc,
  output logic                 anyHead,
  output logic [FLOW_W-1:0]    winFlow,
  output logic                 deqValid,
  output logic [FLOW_W-1:0]    deqFlow,
  output logic [RANK_W-1:0]    deqRank,
  output logic [DESC_W-1:0]    deqDesc
);

  typedef struct packed {
    logic [RANK_W-1:0] rank;
    logic [TAG_W-1:0]  tag;
    logic [DESC_W-1:0] desc;
  } entry_t;

  entry_t                          store [NUM_FLOWS][DEPTH];
  entry_t                          headE [NUM_FLOWS];
  logic [NUM_FLOWS-1:0][PTR_W-1:0] wrPtr, rdPtr;
  logic [TAG_W-1:0]                tagCtr;
  entry_t                          bestE;
  logic                            bestV;
  logic [FLOW_W-1:0]               bestF;

  // a leaves before b: lower rank, or same rank and older tag (modular age)
  function automatic logic leavesFirst(entry_t a, entry_t b);
    logic [TAG_W-1:0] age;
    age = a.tag - b.tag;
    return (a.rank < b.rank) || ((a.rank == b.rank) && age[TAG_W-1]);
  endfunction

  always_comb begin
    for (int f = 0; f < NUM_FLOWS; f++) headE[f] = store[f][rdPtr[f]];
  end

  always_comb begin
    bestV = 1'b0;
    bestF = '0;
    bestE = '0;
    for (int f = 0; f < NUM_FLOWS; f++) begin
      if (nonEmpty[f] && (!bestV || leavesFirst(headE[f], bestE))) begin
        bestV = 1'b1;
        bestF = FLOW_W'(f);
        bestE = headE[f];
      end
    end
  end

  assign anyHead = bestV;
  assign winFlow = bestF;

  always_ff @(posedge clk) begin
    for (int f = 0; f < NUM_FLOWS; f++) begin
      if (strb.push && strb.pushFlow == FLOW_ID_W'(f))
        store[f][wrPtr[f]] <= entry_t'{rank: enqRank, tag: tagCtr, desc: enqDesc};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      tagCtr   <= '0;
      deqValid <= 1'b0;
      deqFlow  <= '0;
      deqRank  <= '0;
      deqDesc  <= '0;
    end else begin
      for (int f = 0; f < NUM_FLOWS; f++) begin
        if (strb.push && strb.pushFlow == FLOW_ID_W'(f)) wrPtr[f] <= wrPtr[f] + PTR_W'(1);
        if (strb.pop && strb.popFlow == FLOW_ID_W'(f))   rdPtr[f] <= rdPtr[f] + PTR_W'(1);
      end
      if (strb.push) tagCtr <= tagCtr + TAG_W'(1);
      deqValid <= strb.pop;
      if (strb.pop) begin
        deqFlow <= bestF;
        deqRank <= bestE.rank;
        deqDesc <= bestE.desc;
      end
    end
  end

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : gen_min_chk
    assert_min_rank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.pop && nonEmpty[g]) |-> (headE[g].rank >= bestE.rank));
  end

endmodule

// File: rtl/rank_sched_queue.sv
module rank_sched_queue
  import rsq_pkg::*;
#(
  parameter int NUM_FLOWS = 16,
  parameter int DEPTH     = 8,
  parameter int RANK_W    = 16,
  parameter int DESC_W    = 16,
  parameter int TAG_W     = 16,
  localparam int FLOW_W   = $clog2(NUM_FLOWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enqValid,
  input  logic [FLOW_W-1:0]    enqFlow,
  input  logic [RANK_W-1:0]    enqRank,
  input  logic [DESC_W-1:0]    enqDesc,
  output logic [NUM_FLOWS-1:0] flowFull,
  input  logic                 deqReq,
  output logic                 deqValid,
  output logic [FLOW_W-1:0]    deqFlow,
  output logic [RANK_W-1:0]    deqRank,
  output logic [DESC_W-1:0]    deqDesc
);

  rsq_strobe_t          strb;
  logic [NUM_FLOWS-1:0] nonEmpty;
  logic                 anyHead;
  logic [FLOW_W-1:0]    winFlow;

  rsq_ctrl #(.NUM_FLOWS(NUM_FLOWS), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enqValid(enqValid), .enqFlow(enqFlow),
    .deqReq(deqReq), .anyHead(anyHead), .winFlow(winFlow),
    .strb(strb), .nonEmpty(nonEmpty), .flowFull(flowFull)
  );

  rsq_datapath #(.NUM_FLOWS(NUM_FLOWS), .DEPTH(DEPTH), .RANK_W(RANK_W),
                 .DESC_W(DESC_W), .TAG_W(TAG_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .nonEmpty(nonEmpty),
    .enqRank(enqRank), .enqDesc(enqDesc), .anyHead(anyHead), .winFlow(winFlow),
    .deqValid(deqValid), .deqFlow(deqFlow), .deqRank(deqRank), .deqDesc(deqDesc)
  );

  assert_empty_noresp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (deqReq && (nonEmpty == '0)) |=> !deqValid);

  assert_resp_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deqValid |-> $past(deqReq));

endmodule

// File: tb/rank_sched_queue_tb.sv
module rank_sched_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF  = 16;
  localparam int DEP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enqValid;
  logic [3:0]    enqFlow;
  logic [15:0]   enqRank;
  logic [15:0]   enqDesc;
  logic [NF-1:0] flowFull;
  logic          deqReq;
  logic          deqValid;
  logic [3:0]    deqFlow;
  logic [15:0]   deqRank;
  logic [15:0]   deqDesc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int mR [NF][DEP];
  int mD [NF][DEP];
  int mS [NF][DEP];
  int mCnt [NF];
  int seqCtr = 0;
  int lastRank [NF];
  int descCtr = 100;
  int lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_sched_queue dut_i (
    .clk(clk), .rst_n(rst_n), .enqValid(enqValid), .enqFlow(enqFlow),
    .enqRank(enqRank), .enqDesc(enqDesc), .flowFull(flowFull), .deqReq(deqReq),
    .deqValid(deqValid), .deqFlow(deqFlow), .deqRank(deqRank), .deqDesc(deqDesc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr & 32'h7fff_ffff;
  endfunction

  // One cycle: drive at negedge, model the edge, check after the edge.
  task automatic step(input bit e, input int fl, input int rk, input int ds,
                      input bit d, input string req);
    bit bv = 0;
    int bf = 0;
    bit expV, canPush;
    int expF, expR, expD;
    @(negedge clk);
    enqValid = e; enqFlow = fl[3:0]; enqRank = rk[15:0]; enqDesc = ds[15:0]; deqReq = d;
    for (int f = 0; f < NF; f++) begin
      if (mCnt[f] > 0 && (!bv || mR[f][0] < mR[bf][0] ||
          (mR[f][0] == mR[bf][0] && mS[f][0] < mS[bf][0]))) begin
        bv = 1; bf = f;
      end
    end
    expV = d && bv;
    expF = bf; expR = mR[bf][0]; expD = mD[bf][0];
    canPush = e && (mCnt[fl] < DEP);
    if (expV) begin
      for (int i = 0; i < DEP - 1; i++) begin
        mR[bf][i] = mR[bf][i+1]; mD[bf][i] = mD[bf][i+1]; mS[bf][i] = mS[bf][i+1];
      end
      mCnt[bf]--;
    end
    if (canPush) begin
      mR[fl][mCnt[fl]] = rk; mD[fl][mCnt[fl]] = ds; mS[fl][mCnt[fl]] = seqCtr;
      mCnt[fl]++; seqCtr++;
    end
    @(posedge clk); #1;
    chk(deqValid == expV, req, int'(deqValid), int'(expV));
    if (expV && deqValid) begin
      chk(int'(deqDesc) == expD, req, int'(deqDesc), expD);
      chk(int'(deqFlow) == expF, "R9", int'(deqFlow), expF);
      chk(int'(deqRank) == expR, "R9", int'(deqRank), expR);
    end
  endtask

  task automatic enq(input int fl, input int rk, input string req);
    step(1, fl, rk, descCtr, 0, req);
    descCtr++;
  endtask

  task automatic deq(input string req);
    step(0, 0, 0, 0, 1, req);
  endtask

  function automatic int modelTotal();
    int t = 0;
    for (int f = 0; f < NF; f++) t += mCnt[f];
    return t;
  endfunction

  task automatic drain(input string req);
    while (modelTotal() > 0) deq(req);
    deq("R4");
  endtask

  task automatic t_reset();
    chk(deqValid == 1'b0, "R7", int'(deqValid), 0);
    chk(flowFull == '0, "R7", int'(flowFull), 0);
    step(0, 0, 0, 0, 0, "R8");
  endtask

  task automatic t_empty();
    deq("R4");
    deq("R4");
    step(1, 2, 10, 77, 1, "R6");
    deq("R6");
    deq("R4");
  endtask

  task automatic t_fifo();
    enq(5, 3, "R3"); enq(5, 3, "R3"); enq(5, 4, "R3"); enq(5, 4, "R3");
    drain("R3");
  endtask

  task automatic t_rank();
    enq(0, 20, "R1"); enq(1, 10, "R1"); enq(0, 30, "R1");
    enq(2, 15, "R1"); enq(1, 25, "R1"); enq(3, 40, "R1");
    drain("R1");
  endtask

  task automatic t_tie();
    enq(3, 7, "R2"); enq(1, 7, "R2"); enq(2, 7, "R2"); enq(1, 7, "R2"); enq(0, 7, "R2");
    drain("R2");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEP; i++) enq(6, 50 + i, "R5");
    chk(flowFull == NF'(1 << 6), "R5", int'(flowFull), 1 << 6);
    step(1, 6, 90, 999, 0, "R5");
    chk(flowFull == NF'(1 << 6), "R5", int'(flowFull), 1 << 6);
    step(1, 6, 91, 998, 1, "R5");
    chk(flowFull == '0, "R5", int'(flowFull), 0);
    drain("R5");
    chk(flowFull == '0, "R5", int'(flowFull), 0);
  endtask

  task automatic t_sameCycle();
    enq(4, 1, "R6");
    step(1, 4, 2, 555, 1, "R6");
    step(1, 9, 0, 556, 1, "R6");
    drain("R6");
  endtask

  task automatic t_random();
    for (int f = 0; f < NF; f++) lastRank[f] = 0;
    for (int i = 0; i < 800; i++) begin
      int fl, rk;
      bit e, d;
      fl = rnd() % NF;
      rk = lastRank[fl] + (rnd() % 3);
      lastRank[fl] = rk;
      e = (rnd() % 4) != 0;
      d = (rnd() % 2) == 0;
      step(e, fl, rk, descCtr, d, "R1");
      descCtr++;
    end
    drain("R1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int f = 0; f < NF; f++) mCnt[f] = 0;
    rst_n = 1'b0; enqValid = 1'b0; enqFlow = '0; enqRank = '0; enqDesc = '0; deqReq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty();
    t_fifo();
    t_rank();
    t_tie();
    t_full();
    t_sameCycle();
    t_random();
    finish_run();
  end
endmodule